// File: doc/BRIEF.md
# Four-Lane Warp Exchange and Vote Unit

This block lets the four lanes of one SIMT warp trade 32-bit values with each other in a single clock, and forms a warp-wide "is any lane still true" vote in the same cycle. A lane can take its own value, the value of the lane whose number differs from its own by a bitwise XOR with a shared operand, the value of a lane that it names itself, or the value of one lane broadcast to the whole warp. Parallel reductions, prefix scans and broadcasts therefore never need to go through memory. For example, a sum over the warp is two XOR exchanges with operands 1 and 2, each followed by an add in the lanes.

The vote is the OR of the lane predicates, taken only over lanes set in the active mask. A branch unit uses it to keep a loop going while any live lane still has work. The exchange results and the vote are registered together, and a valid flag marks the cycle in which they appear. Lane values travel packed into one wide bus, with lane n in bits [32n+31:32n]. The per-lane index bus holds two bits per lane, with lane n in bits [2n+1:2n].

Top module: `shfl_unit`

## Requirements
- R1: With mode code 0 (pass), every lane's result is its own source value.
- R2: With mode code 1 (XOR), lane i receives the source value of lane (i XOR k), where k is the shared 2-bit lane operand, provided that lane is set in the active mask.
- R3: In XOR mode, a lane whose selected source lane is clear in the active mask receives its own source value.
- R4: With mode code 2 (indexed), lane i receives the source value of the lane named by its own 2-bit field, bits [2i+1:2i] of the index bus. The active mask does not affect this mode.
- R5: With mode code 3 (broadcast), every lane receives the source value of lane k. The active mask does not affect this mode.
- R6: The vote output is the OR over all lanes of (predicate AND active bit). It is registered together with the lane results.
- R7: An all-zero active mask yields a vote of 0, whatever the predicates are.
- R8: The output valid flag is high exactly in the cycle after a cycle with the input valid high. The results and the vote for that input appear in that same cycle.
- R9: While the input valid is low, the lane results and the vote keep their previous values.
- R10: Reset clears the output valid flag, all lane results and the vote to 0.
- R11: Two XOR exchanges, first with k = 1 and then with k = 2, each followed by an add in the lanes, leave the sum of all four lanes in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op | input | 2 | Mode: 0 pass, 1 XOR, 2 indexed, 3 broadcast |
| k | input | 2 | Shared lane operand (XOR mask or broadcast source) |
| idx | input | 8 | Per-lane source index, lane n in bits [2n+1:2n] |
| active | input | 4 | Active-lane mask, bit n for lane n |
| src | input | 128 | Lane source values, lane n in bits [32n+31:32n] |
| pred | input | 4 | Lane predicates, bit n for lane n |
| out_valid | output | 1 | Results valid this cycle |
| res | output | 128 | Lane results, lane n in bits [32n+31:32n] |
| vote_any | output | 1 | Registered any-active-lane vote |

## Verification
The bench drives XOR exchanges with each of the three nonzero operands. A design that mirrors lanes in the wrong way, or that treats k = 3 as two separate swaps, returns lane values in the wrong positions. A mask that keeps only alternate lanes active catches a design that applies the mask to the destination lane rather than to the source lane. It also catches a design that zeroes the value instead of keeping the lane's own input. Indexed and broadcast cases read from lanes that are inactive, so a design that wrongly applies the mask in those modes shows up. Predicates that are set only on inactive lanes, and an empty mask with every predicate set, expose a vote that ignores the mask. A two-stage butterfly sum and a hold phase with changed inputs expose a design that updates its registers without valid.

// File: rtl/shfl_pkg.sv
package shfl_pkg;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_XOR   = 2'd1,
        OP_IDX   = 2'd2,
        OP_BCAST = 2'd3
    } shfl_op_e;

    // Source lane chosen for one destination lane (indices up to 8 bits).
    function automatic logic [7:0] pick_src(
        input shfl_op_e   mode,
        input logic [7:0] lane,
        input logic [7:0] shared_k,
        input logic [7:0] own_idx
    );
        logic [7:0] s;
        unique case (mode)
            OP_PASS:  s = lane;
            OP_XOR:   s = lane ^ shared_k;
            OP_IDX:   s = own_idx;
            OP_BCAST: s = shared_k;
            default:  s = lane;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/shfl_lane_mux.sv
module shfl_lane_mux
    import shfl_pkg::*;
#(
    parameter int NL   = 4,
    parameter int DW   = 32,
    parameter int LANE = 0
) (
    input  shfl_op_e                 mode,
    input  logic [$clog2(NL)-1:0]    k,
    input  logic [$clog2(NL)-1:0]    own_idx,
    input  logic [NL-1:0]            active,
    input  logic [NL*DW-1:0]         src,
    output logic [DW-1:0]            y
);
    localparam int LW = $clog2(NL);

    logic [7:0]    pick;
    logic [LW-1:0] sel;
    logic          keep_own;

    always_comb begin
        pick     = pick_src(mode, 8'(LANE), 8'(k), 8'(own_idx));
        sel      = pick[LW-1:0];
        // XOR mode falls back to the lane's own value when its partner is idle.
        keep_own = (mode == OP_XOR) && !active[sel];
        if (keep_own)
            y = src[LANE*DW +: DW];
        else
            y = src[sel*DW +: DW];
    end

endmodule

// File: rtl/shfl_vote.sv
module shfl_vote #(
    parameter int NL = 4
) (
    input  logic [NL-1:0] pred,
    input  logic [NL-1:0] active,
    output logic          any
);
    logic [NL-1:0] live;

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_live
            assign live[g] = pred[g] & active[g];
        end
    endgenerate

    assign any = |live;

endmodule

// File: rtl/shfl_unit.sv
module shfl_unit
    import shfl_pkg::*;
#(
    parameter int NL = 4,
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               op,
    input  logic [$clog2(NL)-1:0]    k,
    input  logic [NL*$clog2(NL)-1:0] idx,
    input  logic [NL-1:0]            active,
    input  logic [NL*DW-1:0]         src,
    input  logic [NL-1:0]            pred,
    output logic                     out_valid,
    output logic [NL*DW-1:0]         res,
    output logic                     vote_any
);
    localparam int LW = $clog2(NL);

    shfl_op_e         mode;
    logic [NL*DW-1:0] xbar;
    logic             vote_c;

    assign mode = shfl_op_e'(op);

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            shfl_lane_mux #(.NL(NL), .DW(DW), .LANE(g)) u_mux (
                .mode    (mode),
                .k       (k),
                .own_idx (idx[g*LW +: LW]),
                .active  (active),
                .src     (src),
                .y       (xbar[g*DW +: DW])
            );
        end
    endgenerate

    shfl_vote #(.NL(NL)) u_vote (
        .pred   (pred),
        .active (active),
        .any    (vote_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '0;
            vote_any  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res      <= xbar;
                vote_any <= vote_c;
            end
        end
    end

endmodule

// File: rtl/shfl_unit_chk.sv
module shfl_unit_chk #(
    parameter int NL = 4,
    parameter int DW = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [1:0]               op,
    input logic [$clog2(NL)-1:0]    k,
    input logic [NL*$clog2(NL)-1:0] idx,
    input logic [NL-1:0]            active,
    input logic [NL*DW-1:0]         src,
    input logic [NL-1:0]            pred,
    input logic                     out_valid,
    input logic [NL*DW-1:0]         res,
    input logic                     vote_any
);
    logic all_same;
    always_comb begin
        all_same = 1'b1;
        for (int i = 1; i < NL; i++)
            if (res[i*DW +: DW] != res[DW-1:0]) all_same = 1'b0;
    end

    a_r8_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res) && $stable(vote_any)));
    a_r6_vote: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (vote_any == $past(|(pred & active))));
    a_r7_empty_vote: assert property (@(posedge clk) disable iff (rst)
        (in_valid && active == '0) |=> !vote_any);
    a_r5_bcast_equal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3) |=> all_same);
    a_r2_xor_lane0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd1 && active == {NL{1'b1}})
        |=> (res[DW-1:0] == $past(src[k*DW +: DW])));
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && res == '0 && !vote_any));

endmodule

bind shfl_unit shfl_unit_chk #(.NL(NL), .DW(DW)) u_chk (.*);

// File: tb/shfl_unit_bench.sv
`timescale 1ns/1ps
module shfl_unit_bench;

    localparam logic [31:0] LA = 32'hA000_0010;
    localparam logic [31:0] LB = 32'hB000_0021;
    localparam logic [31:0] LC = 32'hC000_0032;
    localparam logic [31:0] LD = 32'hD000_0043;

    typedef struct packed {
        logic [1:0]   op;
        logic [1:0]   k;
        logic [7:0]   idx;
        logic [3:0]   act;
        logic [3:0]   pred;
        logic [127:0] exp_res;
        logic         exp_vote;
    } vec_t;

    // res order: {lane3, lane2, lane1, lane0}; src is always {LD,LC,LB,LA}
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 8'h00, 4'hF, 4'h0, {LD, LC, LB, LA}, 1'b0}, // R1
        '{2'd1, 2'd1, 8'h00, 4'hF, 4'h1, {LC, LD, LA, LB}, 1'b1}, // R2 k=1
        '{2'd1, 2'd2, 8'h00, 4'hF, 4'h8, {LB, LA, LD, LC}, 1'b1}, // R2 k=2
        '{2'd1, 2'd3, 8'h00, 4'hF, 4'h0, {LA, LB, LC, LD}, 1'b0}, // R2 k=3
        '{2'd1, 2'd1, 8'h00, 4'h5, 4'hA, {LC, LC, LA, LA}, 1'b0}, // R3, R6
        '{2'd2, 2'd0, 8'h4F, 4'hF, 4'h4, {LB, LA, LD, LD}, 1'b1}, // R4
        '{2'd3, 2'd2, 8'h00, 4'h3, 4'hC, {LC, LC, LC, LC}, 1'b0}, // R5, R6
        '{2'd3, 2'd0, 8'h00, 4'h0, 4'hF, {LA, LA, LA, LA}, 1'b0}, // R5, R7
        '{2'd2, 2'd0, 8'hAA, 4'hB, 4'h2, {LC, LC, LC, LC}, 1'b1}, // R4 inactive src
        '{2'd0, 2'd0, 8'h00, 4'h8, 4'h8, {LD, LC, LB, LA}, 1'b1}  // R1, R6
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   op;
    logic [1:0]   k;
    logic [7:0]   idx;
    logic [3:0]   active;
    logic [127:0] src;
    logic [3:0]   pred;
    logic         out_valid;
    logic [127:0] res;
    logic         vote_any;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shfl_unit u_shfl_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .k(k), .idx(idx),
        .active(active), .src(src), .pred(pred),
        .out_valid(out_valid), .res(res), .vote_any(vote_any)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; results are sampled at the next falling edge.
    task automatic issue(input logic [1:0] o, input logic [1:0] kk, input logic [7:0] ix,
                         input logic [3:0] a, input logic [3:0] p, input logic [127:0] s);
        op = o; k = kk; idx = ix; active = a; pred = p; src = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] stage;
        logic [127:0] sum1;
        logic [127:0] held;
        rst = 1'b1; in_valid = 1'b0; op = 2'd0; k = 2'd0; idx = 8'h00;
        active = 4'h0; src = '0; pred = 4'h0;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk("R10 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R10 res", res, 128'd0);
        chk("R10 vote", {127'd0, vote_any}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 idle valid", {127'd0, out_valid}, 128'd0);

        // Table walk: R1..R7, R8
        for (int v = 0; v < NV; v++) begin
            issue(VEC[v].op, VEC[v].k, VEC[v].idx, VEC[v].act, VEC[v].pred, {LD, LC, LB, LA});
            chk($sformatf("R8 valid vec%0d", v), {127'd0, out_valid}, 128'd1);
            chk($sformatf("R1-5 res vec%0d", v), res, VEC[v].exp_res);
            chk($sformatf("R6/R7 vote vec%0d", v), {127'd0, vote_any}, {127'd0, VEC[v].exp_vote});
        end

        // R9: hold while in_valid low, with changed inputs
        held = res;
        op = 2'd3; k = 2'd1; active = 4'hF; pred = 4'hF; src = ~src;
        @(negedge clk);
        chk("R9 hold res", res, held);
        chk("R9 hold vote", {127'd0, vote_any}, 128'd1);
        chk("R8 valid low", {127'd0, out_valid}, 128'd0);
        pred = 4'h0;
        @(negedge clk);
        chk("R9 hold vote 2", {127'd0, vote_any}, 128'd1);

        // R11: butterfly sum over lanes holding 1,2,3,4
        stage = {32'd4, 32'd3, 32'd2, 32'd1};
        issue(2'd1, 2'd1, 8'h00, 4'hF, 4'h0, stage);
        for (int i = 0; i < 4; i++) sum1[i*32 +: 32] = stage[i*32 +: 32] + res[i*32 +: 32];
        chk("R11 stage1", sum1, {32'd7, 32'd7, 32'd3, 32'd3});
        issue(2'd1, 2'd2, 8'h00, 4'hF, 4'h0, sum1);
        for (int i = 0; i < 4; i++) stage[i*32 +: 32] = sum1[i*32 +: 32] + res[i*32 +: 32];
        chk("R11 total", stage, {32'd10, 32'd10, 32'd10, 32'd10});

        // R10: reset in mid-run clears outputs
        issue(2'd0, 2'd0, 8'h00, 4'hF, 4'hF, {LD, LC, LB, LA});
        rst = 1'b1;
        @(negedge clk);
        chk("R10 re-reset res", res, 128'd0);
        chk("R10 re-reset vote", {127'd0, vote_any}, 128'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule